// File: doc/BRIEF.md
# Broadcast Hub Receive Unit

This unit sits on the receive side of a cluster hub attached to a broadcast ring on which every remote sender owns a private channel. Because no sender ever waits for another, any number of channels can deliver a word in the same cycle. Each word is a 64-bit payload with two metadata fields: a 3-bit message kind (memory read, barrier, raw data and so on) and a 4-bit tag that tells apart several messages in flight from one sender. Every word also carries a destination mask naming the clusters that should keep it.

The unit keeps a word only when the mask bit for its own cluster index is set. Kept words go, payload and metadata together, into a queue owned by the sending channel. Each queue drives a backpressure line back to its sender once it is nearly full. A round-robin selector drains the queues one word per cycle onto a single output toward the local cores, under a valid/ready handshake. A word that reaches a queue that is already full is discarded and counted.

Top module: `hubrx_top`

## Requirements
- R1: All N_SRC channels may present words in the same cycle; every kept word whose queue is not full is stored in that cycle, with no loss caused by simultaneous arrivals.
- R2: A word is kept only if bit MY_HUB (default 2) of its N_HUB-bit destination mask is 1; a word with that bit 0 is dropped and changes no output, no queue and no counter.
- R3: The output presents the payload, kind and tag exactly as they arrived, together with the index of the sending channel on out_src.
- R4: A kept word that arrives while its queue holds DEPTH words is discarded (even if the queue is being drained in the same cycle) and ovf_count grows by one for each such word, saturating at its all-ones value.
- R5: in_hold[i] is 1 exactly when queue i has HOLD_FREE (default 2) or fewer free entries, and follows the queue occupancy one cycle after a store or a drain.
- R6: Words from one sender leave in the order they arrived.
- R7: Selection among non-empty queues is round-robin: the granted channel is the first non-empty one at or after a pointer, and after each transfer the pointer moves to the granted index plus one, wrapping at N_SRC.
- R8: out_valid is 1 whenever at least one queue is non-empty; a word leaves only in a cycle with out_valid and out_ready both 1, and while out_ready is 0 the offered word and out_src stay unchanged.
- R9: After reset all queues are empty, out_valid, in_hold and ovf_count are 0 and the round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_SRC | Per-channel word present |
| in_data | input | N_SRC*DATA_W | Per-channel payload, channel i at bits [i*DATA_W +: DATA_W] |
| in_kind | input | N_SRC*KIND_W | Per-channel message kind |
| in_tag | input | N_SRC*TAG_W | Per-channel message tag |
| in_dmask | input | N_SRC*N_HUB | Per-channel destination mask |
| in_hold | output | N_SRC | Per-channel backpressure toward the sender |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Local cores accept the output word |
| out_data | output | DATA_W | Output payload |
| out_kind | output | KIND_W | Output message kind |
| out_tag | output | TAG_W | Output message tag |
| out_src | output | log2(N_SRC) | Sending channel of the output word |
| ovf_count | output | CNT_W | Saturating count of words lost to full queues |

## Verification
The hard case is a queue that is stored into and drained in the same cycle, including a full queue that is drained while a new word arrives and must still lose that word. The bench provokes it by stalling out_ready until several queues fill, then releasing it while every channel keeps sending, and by phases where all channels send every cycle with out_ready high. A behavioural model with one queue per sender, a pointer and a stall lock predicts every output in every cycle, so a wrong occupancy, a wrong drop decision or a wrong grant shows up as a mismatch in the very cycle it happens.

// File: rtl/hubrx_pkg.sv
package hubrx_pkg;

   function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/hubrx_filter.sv
module hubrx_filter #(
   parameter int N_HUB  = 8,
   parameter int MY_HUB = 2
) (
   input  logic             valid,
   input  logic [N_HUB-1:0] dmask,
   output logic             take
);
   if (MY_HUB < 0 || MY_HUB >= N_HUB) begin : g_bad_hub
      $error("hubrx_filter: MY_HUB outside mask");
   end

   assign take = valid & dmask[MY_HUB];
endmodule

// File: rtl/hubrx_fifo.sv
module hubrx_fifo #(
   parameter int WORD_W    = 71,
   parameter int DEPTH     = 8,
   parameter int HOLD_FREE = 2,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] wdata,
   input  logic              pop,
   output logic [WORD_W-1:0] head,
   output logic              nonempty,
   output logic              full,
   output logic              hold,
   output logic [CW-1:0]     count
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("hubrx_fifo: DEPTH must be a power of two");
   end
   if (HOLD_FREE < 1 || HOLD_FREE >= DEPTH) begin : g_bad_free
      $error("hubrx_fifo: HOLD_FREE out of range");
   end

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] HOLD_CNT = CW'(DEPTH - HOLD_FREE);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr;
   logic [AW-1:0]     rptr;
   logic              do_wr;
   logic              do_rd;

   assign full     = (count == FULL_CNT);
   assign nonempty = (count != '0);
   assign hold     = (count >= HOLD_CNT);
   assign head     = mem[rptr];
   assign do_wr    = push & ~full;
   assign do_rd    = pop & nonempty;

   always_ff @(posedge clk) begin
      if (do_wr) begin
         mem[wptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/hubrx_rr_arb.sv
module hubrx_rr_arb #(
   parameter int N_SRC = 8,
   localparam int SW   = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req,
   input  logic             ready,
   output logic             any,
   output logic [SW-1:0]    grant
);
   import hubrx_pkg::*;

   logic [SW-1:0] ptr;
   logic [SW-1:0] lock_idx;
   logic          locked;
   logic [SW-1:0] scan_idx;

   always_comb begin
      logic found;
      found    = 1'b0;
      scan_idx = ptr;
      for (int k = 0; k < N_SRC; k++) begin
         int unsigned idx;
         idx = (int'(ptr) + k) % N_SRC;
         if (!found && req[idx]) begin
            found    = 1'b1;
            scan_idx = SW'(idx);
         end
      end
   end

   assign any   = |req;
   assign grant = locked ? lock_idx : scan_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= '0;
         lock_idx <= '0;
         locked   <= 1'b0;
      end else if (any && ready) begin
         ptr    <= SW'(wrap_inc(int'(grant), N_SRC));
         locked <= 1'b0;
      end else if (any) begin
         locked   <= 1'b1;
         lock_idx <= grant;
      end else begin
         locked <= 1'b0;
      end
   end
endmodule

// File: rtl/hubrx_ovf_cnt.sv
module hubrx_ovf_cnt #(
   parameter int N_SRC = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] lost,
   output logic [CNT_W-1:0] count
);
   localparam int SUM_W = CNT_W + $clog2(N_SRC + 1);
   localparam logic [SUM_W-1:0] MAX_V = {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

   logic [SUM_W-1:0] next_sum;

   always_comb begin
      next_sum = {{(SUM_W-CNT_W){1'b0}}, count};
      for (int i = 0; i < N_SRC; i++) begin
         next_sum = next_sum + SUM_W'(lost[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (next_sum > MAX_V) begin
         count <= {CNT_W{1'b1}};
      end else begin
         count <= next_sum[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/hubrx_top.sv
module hubrx_top #(
   parameter int N_SRC     = 8,
   parameter int N_HUB     = 8,
   parameter int MY_HUB    = 2,
   parameter int DATA_W    = 64,
   parameter int KIND_W    = 3,
   parameter int TAG_W     = 4,
   parameter int DEPTH     = 8,
   parameter int HOLD_FREE = 2,
   parameter int CNT_W     = 16,
   localparam int WORD_W   = DATA_W + KIND_W + TAG_W,
   localparam int SW       = $clog2(N_SRC),
   localparam int CW       = $clog2(DEPTH) + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_SRC-1:0]          in_valid,
   input  logic [N_SRC*DATA_W-1:0]   in_data,
   input  logic [N_SRC*KIND_W-1:0]   in_kind,
   input  logic [N_SRC*TAG_W-1:0]    in_tag,
   input  logic [N_SRC*N_HUB-1:0]    in_dmask,
   output logic [N_SRC-1:0]          in_hold,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [DATA_W-1:0]         out_data,
   output logic [KIND_W-1:0]         out_kind,
   output logic [TAG_W-1:0]          out_tag,
   output logic [SW-1:0]             out_src,
   output logic [CNT_W-1:0]          ovf_count
);
   if (N_SRC < 2) begin : g_bad_src
      $error("hubrx_top: N_SRC must be at least 2");
   end
   if (DEPTH < 4) begin : g_bad_depth
      $error("hubrx_top: DEPTH must be at least 4");
   end

   logic [N_SRC-1:0]    take;
   logic [N_SRC-1:0]    full;
   logic [N_SRC-1:0]    nonempty;
   logic [N_SRC-1:0]    pop;
   logic [N_SRC-1:0]    lost;
   logic [WORD_W-1:0]   heads [N_SRC];
   logic [N_SRC*CW-1:0] counts;
   logic [SW-1:0]       grant;
   logic                any;
   logic [WORD_W-1:0]   sel_word;

   for (genvar i = 0; i < N_SRC; i++) begin : g_ch
      logic [WORD_W-1:0] wword;

      assign wword = {in_data[i*DATA_W +: DATA_W],
                      in_kind[i*KIND_W +: KIND_W],
                      in_tag[i*TAG_W +: TAG_W]};

      hubrx_filter #(
         .N_HUB  (N_HUB),
         .MY_HUB (MY_HUB)
      ) u_filt (
         .valid (in_valid[i]),
         .dmask (in_dmask[i*N_HUB +: N_HUB]),
         .take  (take[i])
      );

      hubrx_fifo #(
         .WORD_W    (WORD_W),
         .DEPTH     (DEPTH),
         .HOLD_FREE (HOLD_FREE)
      ) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (take[i]),
         .wdata    (wword),
         .pop      (pop[i]),
         .head     (heads[i]),
         .nonempty (nonempty[i]),
         .full     (full[i]),
         .hold     (in_hold[i]),
         .count    (counts[i*CW +: CW])
      );

      assign pop[i]  = any & out_ready & (grant == SW'(i));
      assign lost[i] = take[i] & full[i];
   end

   hubrx_rr_arb #(
      .N_SRC (N_SRC)
   ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (nonempty),
      .ready (out_ready),
      .any   (any),
      .grant (grant)
   );

   hubrx_ovf_cnt #(
      .N_SRC (N_SRC),
      .CNT_W (CNT_W)
   ) u_ovf (
      .clk   (clk),
      .rst_n (rst_n),
      .lost  (lost),
      .count (ovf_count)
   );

   assign sel_word  = heads[grant];
   assign out_valid = any;
   assign out_src   = grant;
   assign out_data  = sel_word[WORD_W-1 -: DATA_W];
   assign out_kind  = sel_word[TAG_W +: KIND_W];
   assign out_tag   = sel_word[TAG_W-1:0];
endmodule

// File: rtl/hubrx_chk.sv
module hubrx_chk #(
   parameter int N_SRC = 8,
   parameter int DEPTH = 8,
   parameter int CNT_W = 16,
   parameter int SW    = 3,
   parameter int CW    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                out_valid,
   input logic                out_ready,
   input logic [SW-1:0]       out_src,
   input logic [63:0]         out_data,
   input logic [CNT_W-1:0]    ovf_count,
   input logic [N_SRC-1:0]    nonempty,
   input logic [N_SRC-1:0]    pop,
   input logic [N_SRC*CW-1:0] counts
);
   // R7: at most one queue drained per cycle
   p_one_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pop));

   // R3: the offered word comes from a queue that holds data
   p_src_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> nonempty[out_src]);

   // R4: loss counter never moves backwards
   p_ovf_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ovf_count >= $past(ovf_count));

   // R8: a stalled offer holds still
   p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_src) && $stable(out_data)));

   // R8: a transfer removes exactly one word from the granted queue
   for (genvar i = 0; i < N_SRC; i++) begin : g_q
      p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
         counts[i*CW +: CW] <= CW'(DEPTH));
      p_pop_needs_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
         pop[i] |-> (out_ready && out_valid && out_src == SW'(i)));
   end
endmodule

bind hubrx_top hubrx_chk #(
   .N_SRC (N_SRC),
   .DEPTH (DEPTH),
   .CNT_W (CNT_W),
   .SW    (SW),
   .CW    (CW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_src   (out_src),
   .out_data  (out_data),
   .ovf_count (ovf_count),
   .nonempty  (nonempty),
   .pop       (pop),
   .counts    (counts)
);

// File: tb/tb_hubrx_top.sv
`timescale 1ns/1ps
module tb_hubrx_top;
   localparam int N_SRC = 8, N_HUB = 8, MY_HUB = 2;
   localparam int DATA_W = 64, KIND_W = 3, TAG_W = 4;
   localparam int DEPTH = 8, HOLD_FREE = 2, CNT_W = 16;
   localparam int WORD_W = DATA_W + KIND_W + TAG_W;
   localparam int SW = $clog2(N_SRC);

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [N_SRC-1:0]        in_valid = '0;
   logic [N_SRC*DATA_W-1:0] in_data = '0;
   logic [N_SRC*KIND_W-1:0] in_kind = '0;
   logic [N_SRC*TAG_W-1:0]  in_tag = '0;
   logic [N_SRC*N_HUB-1:0]  in_dmask = '0;
   logic [N_SRC-1:0]        in_hold;
   logic                    out_valid;
   logic                    out_ready = 1'b0;
   logic [DATA_W-1:0]       out_data;
   logic [KIND_W-1:0]       out_kind;
   logic [TAG_W-1:0]        out_tag;
   logic [SW-1:0]           out_src;
   logic [CNT_W-1:0]        ovf_count;

   always #2.5 clk = ~clk;

   hubrx_top #(
      .N_SRC(N_SRC), .N_HUB(N_HUB), .MY_HUB(MY_HUB), .DATA_W(DATA_W),
      .KIND_W(KIND_W), .TAG_W(TAG_W), .DEPTH(DEPTH), .HOLD_FREE(HOLD_FREE),
      .CNT_W(CNT_W)
   ) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_kind(in_kind), .in_tag(in_tag), .in_dmask(in_dmask),
      .in_hold(in_hold), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_kind(out_kind), .out_tag(out_tag),
      .out_src(out_src), .ovf_count(ovf_count)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;

   logic [WORD_W-1:0] mq [N_SRC][$];
   int m_ptr = 0;
   bit m_lock = 0;
   int m_lidx = 0;
   int m_ovf = 0;

   function automatic int m_grant();
      if (m_lock) return m_lidx;
      for (int k = 0; k < N_SRC; k++) begin
         int idx = (m_ptr + k) % N_SRC;
         if (mq[idx].size() > 0) return idx;
      end
      return m_ptr;
   endfunction

   function automatic bit m_any();
      for (int i = 0; i < N_SRC; i++) if (mq[i].size() > 0) return 1;
      return 0;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, what, cyc, act, exp);
      end
   endtask

   // compare outputs with model state (called away from the clock edge)
   task automatic compare(input string req);
      bit ev;
      int g;
      logic [N_SRC-1:0] eh;
      ev = m_any();
      g  = m_grant();
      check(out_valid == ev, req, "R8 out_valid", out_valid, ev);
      if (ev && out_valid) begin
         logic [WORD_W-1:0] w;
         w = mq[g][0];
         check(out_src == SW'(g), req, "R7 out_src", out_src, g);
         check({out_data, out_kind, out_tag} == w, req, "R3/R6 word",
               longint'(out_data), longint'(w[WORD_W-1 -: DATA_W]));
      end
      for (int i = 0; i < N_SRC; i++) eh[i] = (DEPTH - mq[i].size()) <= HOLD_FREE;
      check(in_hold == eh, req, "R5 in_hold", in_hold, eh);
      check(int'(ovf_count) == m_ovf, req, "R4 ovf_count", ovf_count, m_ovf);
   endtask

   // advance model across the next rising edge using current inputs
   task automatic model_step();
      bit ev;
      int g;
      int pre [N_SRC];
      ev = m_any();
      g  = m_grant();
      for (int i = 0; i < N_SRC; i++) pre[i] = mq[i].size();
      if (ev && out_ready) begin
         void'(mq[g].pop_front());
         m_ptr  = (g + 1) % N_SRC;
         m_lock = 0;
      end else if (ev) begin
         m_lock = 1;
         m_lidx = g;
      end else begin
         m_lock = 0;
      end
      for (int i = 0; i < N_SRC; i++) begin
         if (in_valid[i] && in_dmask[i*N_HUB + MY_HUB]) begin
            if (pre[i] == DEPTH) begin
               if (m_ovf < (1 << CNT_W) - 1) m_ovf++;
            end else begin
               mq[i].push_back({in_data[i*DATA_W +: DATA_W],
                                in_kind[i*KIND_W +: KIND_W],
                                in_tag[i*TAG_W +: TAG_W]});
            end
         end
      end
   endtask

   // one cycle: compare, drive, model, edge
   task automatic cycle(input string req, input int vpct, input int mine_pct,
                        input int rdy_pct);
      @(negedge clk);
      compare(req);
      for (int i = 0; i < N_SRC; i++) begin
         logic [N_HUB-1:0] m;
         in_valid[i] = ($urandom_range(99) < vpct);
         in_data[i*DATA_W +: DATA_W] = {32'(cyc), 24'($urandom), 8'(i)};
         in_kind[i*KIND_W +: KIND_W] = KIND_W'($urandom);
         in_tag[i*TAG_W +: TAG_W]    = TAG_W'($urandom);
         m = N_HUB'($urandom);
         m[MY_HUB] = ($urandom_range(99) < mine_pct);
         in_dmask[i*N_HUB +: N_HUB] = m;
      end
      out_ready = ($urandom_range(99) < rdy_pct);
      model_step();
      cyc++;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      @(negedge clk);
      check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
      check(in_hold == '0, "R9", "in_hold after reset", in_hold, 0);
      check(ovf_count == '0, "R9", "ovf_count after reset", ovf_count, 0);
      // R2: words without the own mask bit never enter
      for (int n = 0; n < 40; n++) cycle("R2", 100, 0, 50);
      // R7/R6: mixed traffic with random ready
      for (int n = 0; n < 1500; n++) cycle("R7", 40, 70, 60);
      // R8/R4: long stall fills queues, then overflow
      for (int n = 0; n < 60; n++) cycle("R8", 60, 100, 0);
      // R4: full queues drained while every channel keeps sending
      for (int n = 0; n < 200; n++) cycle("R4", 100, 100, 100);
      // R1: all channels every cycle with sparse ready
      for (int n = 0; n < 800; n++) cycle("R1", 100, 90, 30);
      // R5: light traffic around the hold threshold
      for (int n = 0; n < 1500; n++) cycle("R5", 15, 100, 15);
      // drain and idle: nothing left, R2 filtered words only
      for (int n = 0; n < 120; n++) cycle("R6", 0, 0, 100);
      @(negedge clk);
      compare("R9");
      check(out_valid == 1'b0, "R6", "all queues drained", out_valid, 0);
      finish_run();
   end

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog expired cycle=%0d actual=running expected=finished", cyc);
      finish_run();
   end
endmodule